// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a two-part logical address, made of a segment selector and an offset, to a flat physical address. The mapping comes from a small table held in registers. Each entry gives a segment's starting physical address and its length. A translation request reads the selected entry. It checks the offset against the length, and on success it adds the offset to the start address. An offset that falls outside the segment produces an invalid-address fault, and no address is produced.

Software loads the table through a one-entry-per-cycle write port. The translate port takes one request per cycle, and each result appears one clock later. If a write and a translation hit the same entry in the same cycle, the translation sees the newly written values. A selector that names a slot beyond the implemented table faults in the same way as an out-of-range offset.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry has start 0 and length 0, so any translation faults and all response outputs are low/zero until a request is made.
- R2: `rsp_valid_o` is high exactly in the cycle after a cycle in which `req_valid_i` was high.
- R3: When the selected entry exists and offset < length, the response has `rsp_ok_o`=1, `rsp_fault_o`=0 and `rsp_paddr_o` = start + offset, computed at full width (PA_W = max(BASE_W, OFF_W)+1 bits, with no truncation).
- R4: When offset >= length, including offset equal to length, the response has `rsp_fault_o`=1, `rsp_ok_o`=0 and `rsp_paddr_o`=0.
- R5: A request whose selector is NUM_SEG or larger faults, with the same outputs as R4.
- R6: A write with `wr_en_i`=1 stores start and length into the entry that `wr_seg_i` names, and later translations use them. A write whose selector is NUM_SEG or larger changes no entry.
- R7: A write and a request that name the same entry in the same cycle give a response computed from the newly written start and length.
- R8: In a cycle where `rsp_valid_o` is 0, `rsp_ok_o` and `rsp_fault_o` are 0 and `rsp_paddr_o` is 0.
- R9: Whenever `rsp_valid_o` is 1, exactly one of `rsp_ok_o` and `rsp_fault_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_seg_i | input | SEG_W | Entry selected for the write |
| wr_base_i | input | BASE_W | Segment start address to store |
| wr_limit_i | input | OFF_W+1 | Segment length to store |
| req_valid_i | input | 1 | Translation request strobe |
| req_seg_i | input | SEG_W | Segment selector of the request |
| req_off_i | input | OFF_W | Offset within the segment |
| rsp_valid_o | output | 1 | Response present |
| rsp_ok_o | output | 1 | Translation succeeded |
| rsp_fault_o | output | 1 | Invalid-address fault |
| rsp_paddr_o | output | PA_W | Physical address, zero when the translation faults |

## Verification
Directed requests first use a pair of entries with known start and length. They probe an offset well inside the segment, one just below the length, one exactly at the length and one past it, which separates a correct strict comparison from a less-or-equal one. A start at its maximum combined with a maximum offset shows whether the sum carries into the top bit or is cut off. Other directed requests use a selector past the table, make a write to an unimplemented slot that could alias onto entry 0, and make a same-cycle write and request to one entry; these show whether the bounds guard and the write forwarding work. Seeded random writes and requests then mix all these cases against a reference model of the table kept in the bench.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef struct packed {
    logic valid;
    logic ok;
    logic fault;
  } rsp_flags_t;

  function automatic int unsigned max_w(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seg_table_regs.sv
module seg_table_regs #(
  parameter int unsigned NUM_SEG = 8,
  parameter int unsigned SEG_W   = 4,
  parameter int unsigned BASE_W  = 16,
  parameter int unsigned LIM_W   = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic [LIM_W-1:0]  wr_limit_i,
  input  logic [SEG_W-1:0]  rd_seg_i,
  output logic [BASE_W-1:0] rd_base_o,
  output logic [LIM_W-1:0]  rd_limit_o,
  output logic              rd_hit_o
);

  logic [BASE_W-1:0] base_q  [NUM_SEG];
  logic [LIM_W-1:0]  limit_q [NUM_SEG];
  logic [NUM_SEG-1:0] wr_sel;
  logic [NUM_SEG-1:0] rd_sel;

  // per-entry decode; selectors past the table match nothing
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_dec
    assign wr_sel[g] = wr_en_i && (wr_seg_i == SEG_W'(g));
    assign rd_sel[g] = (rd_seg_i == SEG_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (wr_sel[i]) begin
          base_q[i]  <= wr_base_i;
          limit_q[i] <= wr_limit_i;
        end
      end
    end
  end

  // read mux with same-cycle write forwarding
  always_comb begin
    rd_base_o  = '0;
    rd_limit_o = '0;
    rd_hit_o   = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_sel[i]) begin
        rd_hit_o   = 1'b1;
        rd_base_o  = wr_sel[i] ? wr_base_i  : base_q[i];
        rd_limit_o = wr_sel[i] ? wr_limit_i : limit_q[i];
      end
    end
  end

endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned LIM_W = OFF_W + 1
) (
  input  logic             seg_hit_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             pass_o
);

  // valid offsets are 0 .. limit-1
  assign pass_o = seg_hit_i && (LIM_W'(off_i) < limit_i);

endmodule

// File: rtl/seg_addr_add.sv
module seg_addr_add #(
  parameter int unsigned BASE_W = 16,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 17
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [PA_W-1:0]   sum_o
);

  assign sum_o = PA_W'(base_i) + PA_W'(off_i);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter  int unsigned NUM_SEG = 8,
  parameter  int unsigned SEG_W   = 4,
  parameter  int unsigned OFF_W   = 12,
  parameter  int unsigned BASE_W  = 16,
  localparam int unsigned LIM_W   = OFF_W + 1,
  localparam int unsigned PA_W    = seg_xlate_pkg::max_w(BASE_W, OFF_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic [LIM_W-1:0]  wr_limit_i,
  input  logic              req_valid_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              rsp_fault_o,
  output logic [PA_W-1:0]   rsp_paddr_o
);

  logic [BASE_W-1:0] ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic              ent_hit;
  logic              in_bounds;
  logic [PA_W-1:0]   sum;

  seg_xlate_pkg::rsp_flags_t flags_d, flags_q;
  logic [PA_W-1:0]           paddr_q;

  seg_table_regs #(
    .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_seg_i   (wr_seg_i),
    .wr_base_i  (wr_base_i),
    .wr_limit_i (wr_limit_i),
    .rd_seg_i   (req_seg_i),
    .rd_base_o  (ent_base),
    .rd_limit_o (ent_limit),
    .rd_hit_o   (ent_hit)
  );

  seg_bound_check #(.OFF_W(OFF_W), .LIM_W(LIM_W)) u_bound (
    .seg_hit_i (ent_hit),
    .off_i     (req_off_i),
    .limit_i   (ent_limit),
    .pass_o    (in_bounds)
  );

  seg_addr_add #(.BASE_W(BASE_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_add (
    .base_i (ent_base),
    .off_i  (req_off_i),
    .sum_o  (sum)
  );

  always_comb begin
    flags_d.valid = req_valid_i;
    flags_d.ok    = req_valid_i && in_bounds;
    flags_d.fault = req_valid_i && !in_bounds;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      paddr_q <= '0;
    end else begin
      flags_q <= flags_d;
      paddr_q <= flags_d.ok ? sum : '0;
    end
  end

  assign rsp_valid_o = flags_q.valid;
  assign rsp_ok_o    = flags_q.ok;
  assign rsp_fault_o = flags_q.fault;
  assign rsp_paddr_o = paddr_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter  int unsigned NUM_SEG = 8,
  parameter  int unsigned SEG_W   = 4,
  parameter  int unsigned OFF_W   = 12,
  parameter  int unsigned BASE_W  = 16,
  localparam int unsigned LIM_W   = OFF_W + 1,
  localparam int unsigned PA_W    = seg_xlate_pkg::max_w(BASE_W, OFF_W) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [SEG_W-1:0]  wr_seg_i,
  input logic [BASE_W-1:0] wr_base_i,
  input logic [LIM_W-1:0]  wr_limit_i,
  input logic              req_valid_i,
  input logic [SEG_W-1:0]  req_seg_i,
  input logic [OFF_W-1:0]  req_off_i,
  input logic              rsp_valid_o,
  input logic              rsp_ok_o,
  input logic              rsp_fault_o,
  input logic [PA_W-1:0]   rsp_paddr_o
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R9
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_ok_o, rsp_fault_o}) == 1));

  // R8
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_ok_o && !rsp_fault_o && rsp_paddr_o == '0));

  // R4
  fault_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_paddr_o == '0));

  // R5
  oob_seg_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (32'(req_seg_i) >= NUM_SEG)) |=> rsp_fault_o);

  // R7
  fwd_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && req_valid_i && wr_seg_i == req_seg_i && (32'(req_seg_i) < NUM_SEG)
     && (LIM_W'(req_off_i) < wr_limit_i))
    |=> (rsp_ok_o && rsp_paddr_o == PA_W'($past(wr_base_i)) + PA_W'($past(req_off_i))));

endmodule

bind seg_xlate seg_xlate_chk #(
  .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)
) u_chk (.*);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

  localparam int unsigned NUM_SEG = 8;
  localparam int unsigned SEG_W   = 4;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned BASE_W  = 16;
  localparam int unsigned LIM_W   = 13;
  localparam int unsigned PA_W    = 17;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [SEG_W-1:0]  wr_seg_i = '0;
  logic [BASE_W-1:0] wr_base_i = '0;
  logic [LIM_W-1:0]  wr_limit_i = '0;
  logic              req_valid_i = 1'b0;
  logic [SEG_W-1:0]  req_seg_i = '0;
  logic [OFF_W-1:0]  req_off_i = '0;
  logic              rsp_valid_o;
  logic              rsp_ok_o;
  logic              rsp_fault_o;
  logic [PA_W-1:0]   rsp_paddr_o;

  seg_xlate #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_seg_xlate (
    .clk_i, .rst_ni, .wr_en_i, .wr_seg_i, .wr_base_i, .wr_limit_i,
    .req_valid_i, .req_seg_i, .req_off_i,
    .rsp_valid_o, .rsp_ok_o, .rsp_fault_o, .rsp_paddr_o
  );

  always #4 clk_i = ~clk_i;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [BASE_W-1:0] ref_base [NUM_SEG];
  logic [LIM_W-1:0]  ref_lim  [NUM_SEG];

  task automatic chk(bit cond, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] expect_rsp(logic rv, logic [SEG_W-1:0] s, logic [OFF_W-1:0] o);
    logic ok;
    logic [PA_W-1:0] pa;
    ok = 1'b0;
    pa = '0;
    if (rv && 32'(s) < NUM_SEG && LIM_W'(o) < ref_lim[s[2:0]]) begin
      ok = 1'b1;
      pa = PA_W'(ref_base[s[2:0]]) + PA_W'(o);
    end
    return {rv, ok, rv && !ok, pa};
  endfunction

  // drives one cycle at a negedge, checks the registered response at the next negedge
  task automatic cycle(logic we, logic [SEG_W-1:0] ws, logic [BASE_W-1:0] wb,
                       logic [LIM_W-1:0] wl, logic rv, logic [SEG_W-1:0] rs,
                       logic [OFF_W-1:0] ro, string tag = "");
    logic [19:0] e;
    string t;
    wr_en_i = we; wr_seg_i = ws; wr_base_i = wb; wr_limit_i = wl;
    req_valid_i = rv; req_seg_i = rs; req_off_i = ro;
    if (we && 32'(ws) < NUM_SEG) begin
      ref_base[ws[2:0]] = wb;
      ref_lim[ws[2:0]]  = wl;
    end
    e = expect_rsp(rv, rs, ro);
    if (tag != "") t = tag;
    else if (!rv) t = "R8";
    else if (32'(rs) >= NUM_SEG) t = "R5";
    else if (we && ws == rs) t = "R7";
    else if (e[18]) t = "R3";
    else t = "R4";
    @(negedge clk_i);
    chk({rsp_valid_o, rsp_ok_o, rsp_fault_o, rsp_paddr_o} == e, t,
        32'({rsp_valid_o, rsp_ok_o, rsp_fault_o, rsp_paddr_o}), 32'(e));
  endtask

  task automatic wr(logic [SEG_W-1:0] s, logic [BASE_W-1:0] b, logic [LIM_W-1:0] l, string tag = "");
    cycle(1'b1, s, b, l, 1'b0, '0, '0, tag);
  endtask

  task automatic rd(logic [SEG_W-1:0] s, logic [OFF_W-1:0] o, string tag = "");
    cycle(1'b0, '0, '0, '0, 1'b1, s, o, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_SEG; i++) begin
      ref_base[i] = '0;
      ref_lim[i]  = '0;
    end
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet while in reset
    chk({rsp_valid_o, rsp_ok_o, rsp_fault_o, rsp_paddr_o} == '0, "R1",
        32'({rsp_valid_o, rsp_ok_o, rsp_fault_o, rsp_paddr_o}), 32'd0);
    rst_ni = 1'b1;
    // R1: empty table faults every in-range selector
    rd(4'd3, 12'd0, "R1");
    rd(4'd0, 12'd1, "R1");

    wr(4'd2, 16'd2200, 13'd780, "R6");
    wr(4'd4, 16'd1650, 13'd400, "R6");
    rd(4'd2, 12'd247);   // R3: 2447
    rd(4'd2, 12'd0);     // R3
    rd(4'd2, 12'd779);   // R3 last valid
    rd(4'd2, 12'd780);   // R4 equal to length
    rd(4'd4, 12'd439);   // R4
    rd(4'd4, 12'd400);   // R4 boundary
    rd(4'd4, 12'd399);   // R3 boundary
    rd(4'd9, 12'd0);     // R5
    rd(4'd15, 12'd5);    // R5
    cycle(1'b0, '0, '0, '0, 1'b0, '0, '0);  // R8, R2

    // R6: write to slot 8 must not alias onto entry 0
    wr(4'd0, 16'd100, 13'd50, "R6");
    wr(4'd8, 16'd777, 13'd4000, "R6");
    rd(4'd0, 12'd49, "R6");
    rd(4'd0, 12'd50, "R6");

    // R7: same-cycle write and request
    cycle(1'b1, 4'd2, 16'd5000, 13'd10, 1'b1, 4'd2, 12'd9);
    cycle(1'b1, 4'd4, 16'd9, 13'd0, 1'b1, 4'd4, 12'd0);

    // R3: full-width sum, maximum length
    wr(4'd7, 16'hFFFF, 13'h1000, "R6");
    rd(4'd7, 12'hFFF);
    rd(4'd7, 12'h000);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic we, rv;
      logic [SEG_W-1:0] ws, rs;
      logic [OFF_W-1:0] ro;
      logic [LIM_W-1:0] wl;
      we = ($urandom_range(0, 3) == 0);
      rv = ($urandom_range(0, 4) != 0);
      ws = SEG_W'($urandom_range(0, 9));
      rs = ($urandom_range(0, 5) == 0) ? ws : SEG_W'($urandom_range(0, 9));
      wl = LIM_W'($urandom_range(0, 4096));
      ro = ($urandom_range(0, 3) == 0) ? OFF_W'(ref_lim[rs[2:0]]) : OFF_W'($urandom_range(0, 4095));
      cycle(we, ws, 16'($urandom), wl, rv, rs, ro);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule